// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for two requesters: an instruction fetch port and a data access port. Each port owns a small fully-associative first-level buffer, and both fall back to one shared fully-associative second-level buffer. Every entry maps one of four page sizes, and the page size decides both which virtual bits are compared and which bits pass through unchanged into the physical address.

A request that hits its port's first-level buffer completes in the cycle it is presented. A first-level miss stalls the port for one cycle while the shared buffer is searched. A hit there completes the request and copies the entry into that port's first-level buffer over a round-robin victim. A miss there completes the request with a page-miss fault and no translation. Software loads the shared buffer through an indexed write port, and a flush input empties all three buffers at once.

Top module: `dual_port_tlb`

## Requirements
- R1: A request whose address hits the port's first-level buffer has ready high in the first cycle of the request, with the translated address on the port.
- R2: A first-level miss holds ready low for exactly one cycle; in the next cycle a shared-buffer hit gives ready with the translation, and a later request to the same page hits first-level with no stall.
- R3: A first-level miss that also misses the shared buffer gives ready and fault high one cycle after the request, with the physical address output zero; nothing is copied, so a repeat of the request again stalls one cycle and faults.
- R4: The 2-bit size code selects the page: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. Virtual bits [31:10], [31:12], [31:16] or [31:20] are compared, and the bits below them are taken from the virtual address into the physical address.
- R5: The instruction-side buffer holds 4 entries and the data-side buffer 8, replaced in round-robin order: after five distinct pages are refilled on the instruction side the oldest misses, while the data side still holds all five.
- R6: When both ports miss first-level in the same cycle, the data port completes one cycle later and the instruction port two cycles later.
- R7: Any write to the shared buffer empties both first-level buffers, so the next request to a previously held page stalls one cycle.
- R8: A flush pulse clears the valid bits of all three buffers; a following request faults.
- R9: When several valid shared-buffer entries match an address, the entry with the lowest index supplies the translation.
- R10: Writing an index with the valid bit low removes that mapping; a request to it then faults.
- R11: After reset both ports show ready and fault low while idle, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear all buffers |
| i_req | input | 1 | Instruction request, held until ready |
| i_va | input | 32 | Instruction virtual address |
| i_rdy | output | 1 | Instruction request complete |
| i_pa | output | 32 | Instruction physical address |
| i_fault | output | 1 | Instruction page miss |
| d_req | input | 1 | Data request, held until ready |
| d_va | input | 32 | Data virtual address |
| d_rdy | output | 1 | Data request complete |
| d_pa | output | 32 | Data physical address |
| d_fault | output | 1 | Data page miss |
| wr_en | input | 1 | Shared-buffer write strobe |
| wr_idx | input | 5 | Entry index written |
| wr_valid | input | 1 | Valid bit written |
| wr_vpn | input | 22 | Virtual page bits [31:10] |
| wr_ppn | input | 22 | Physical page bits [31:10] |
| wr_size | input | 2 | Page size code |

## Verification
A corrupt first-level entry shows on the very next request to that page as a wrong address with no stall, while a lost first-level entry shows as a one-cycle stall where none was expected, so the bench checks the completion latency of every request as well as its result. A wrong size mask or merge appears as a wrong low-order address field on the first access through that entry. A broken round-robin pointer or arbitration order appears within a handful of requests as a stall pattern that differs from the expected one.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int SZ_W   = 2;

  typedef struct packed {
    logic             vld;
    logic [SZ_W-1:0]  sz;
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
  } tlb_ent_t;

  // ones on page-number bits that take part in the compare
  function automatic logic [VPN_W-1:0] sz_mask(input logic [SZ_W-1:0] sz);
    logic [VPN_W-1:0] m;
    case (sz)
      2'b00:   m = '1;
      2'b01:   m = ~VPN_W'(22'h3);
      2'b10:   m = ~VPN_W'(22'h3F);
      default: m = ~VPN_W'(22'h3FF);
    endcase
    return m;
  endfunction

  function automatic logic ent_hit(input tlb_ent_t e, input logic [VA_W-1:0] va);
    return e.vld && (((va[VA_W-1:PG_LSB] ^ e.vpn) & sz_mask(e.sz)) == '0);
  endfunction

  function automatic logic [VA_W-1:0] ent_xlate(input tlb_ent_t e, input logic [VA_W-1:0] va);
    logic [VPN_W-1:0] m;
    m = sz_mask(e.sz);
    return {(e.ppn & m) | (va[VA_W-1:PG_LSB] & ~m), va[PG_LSB-1:0]};
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb2_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [VA_W-1:0] lk_va,
  output logic            lk_hit,
  output tlb_ent_t        lk_ent,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  tlb_ent_t        wr_ent
);
  tlb_ent_t         ent_q [N];
  logic [N-1:0]     mvec;
  logic [IW-1:0]    sel;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < N; k++) ent_q[k].vld <= 1'b0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_ent;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign mvec[g] = ent_hit(ent_q[g], lk_va);
  end

  // scan downward so the lowest matching index is the last one kept
  always_comb begin
    sel = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (mvec[k]) sel = IW'(k);
    end
  end

  assign lk_hit = |mvec;
  assign lk_ent = ent_q[sel];

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !lk_hit);
endmodule

// File: rtl/micro_tlb.sv
module micro_tlb
  import tlb2_pkg::*;
#(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [VA_W-1:0] lk_va,
  output logic            hit,
  output tlb_ent_t        ent,
  input  logic            fill_en,
  input  tlb_ent_t        fill_ent
);
  logic [IW-1:0] vic_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_q <= '0;
    end else if (fill_en && !clr) begin
      vic_q <= (vic_q == IW'(N - 1)) ? '0 : vic_q + 1'b1;
    end
  end

  tlb_cam #(.N(N)) u_cam (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .lk_va  (lk_va),
    .lk_hit (hit),
    .lk_ent (ent),
    .wr_en  (fill_en),
    .wr_idx (vic_q),
    .wr_ent (fill_ent)
  );

  // R2
  fill_hits_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en && !clr && $stable(lk_va) ##0 ent_hit(fill_ent, lk_va) |=> hit || clr);
endmodule

// File: rtl/dual_port_tlb.sv
module dual_port_tlb
  import tlb2_pkg::*;
#(
  parameter int MAIN_N = 32,
  parameter int ITLB_N = 4,
  parameter int DTLB_N = 8,
  localparam int MIW   = $clog2(MAIN_N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            i_req,
  input  logic [31:0]     i_va,
  output logic            i_rdy,
  output logic [31:0]     i_pa,
  output logic            i_fault,
  input  logic            d_req,
  input  logic [31:0]     d_va,
  output logic            d_rdy,
  output logic [31:0]     d_pa,
  output logic            d_fault,
  input  logic            wr_en,
  input  logic [MIW-1:0]  wr_idx,
  input  logic            wr_valid,
  input  logic [21:0]     wr_vpn,
  input  logic [21:0]     wr_ppn,
  input  logic [1:0]      wr_size
);
  logic      i_pend_q, d_pend_q;
  logic      i_serve, d_serve;
  logic      i_uhit, d_uhit, m_hit;
  tlb_ent_t  i_uent, d_uent, m_ent, m_wr;
  logic [VA_W-1:0] m_va;
  logic      u_clr, i_fill, d_fill;

  assign d_serve = d_req && d_pend_q;
  assign i_serve = i_req && i_pend_q && !d_serve;
  assign m_va    = d_serve ? d_va : i_va;
  assign u_clr   = flush || wr_en;
  assign d_fill  = d_serve && m_hit && !u_clr;
  assign i_fill  = i_serve && m_hit && !u_clr;
  assign m_wr    = '{vld: wr_valid, sz: wr_size, vpn: wr_vpn, ppn: wr_ppn};

  always_ff @(posedge clk) begin
    if (rst) begin
      i_pend_q <= 1'b0;
      d_pend_q <= 1'b0;
    end else begin
      i_pend_q <= i_req && !i_rdy;
      d_pend_q <= d_req && !d_rdy;
    end
  end

  micro_tlb #(.N(ITLB_N)) u_itlb (
    .clk(clk), .rst(rst), .clr(u_clr), .lk_va(i_va),
    .hit(i_uhit), .ent(i_uent), .fill_en(i_fill), .fill_ent(m_ent)
  );

  micro_tlb #(.N(DTLB_N)) u_dtlb (
    .clk(clk), .rst(rst), .clr(u_clr), .lk_va(d_va),
    .hit(d_uhit), .ent(d_uent), .fill_en(d_fill), .fill_ent(m_ent)
  );

  tlb_cam #(.N(MAIN_N)) u_main (
    .clk(clk), .rst(rst), .clr(flush), .lk_va(m_va),
    .lk_hit(m_hit), .lk_ent(m_ent),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(m_wr)
  );

  always_comb begin
    d_rdy   = d_req && (d_serve || (!d_pend_q && d_uhit));
    d_fault = d_serve && !m_hit;
    d_pa    = '0;
    if (d_serve) begin
      if (m_hit) d_pa = ent_xlate(m_ent, d_va);
    end else if (d_rdy) begin
      d_pa = ent_xlate(d_uent, d_va);
    end
  end

  always_comb begin
    i_rdy   = i_req && (i_serve || (!i_pend_q && i_uhit));
    i_fault = i_serve && !m_hit;
    i_pa    = '0;
    if (i_serve) begin
      if (m_hit) i_pa = ent_xlate(m_ent, i_va);
    end else if (i_rdy) begin
      i_pa = ent_xlate(i_uent, i_va);
    end
  end

  // R2
  d_one_stall_chk: assert property (@(posedge clk) disable iff (rst)
    d_req && !d_rdy |=> d_rdy || !d_req);
  // R3
  d_fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    d_fault |-> d_rdy && (d_pa == '0));
  // R3
  i_fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    i_fault |-> i_rdy && (i_pa == '0));
  // R6
  data_first_chk: assert property (@(posedge clk) disable iff (rst)
    d_req && !d_rdy && i_req && !i_rdy && !d_pend_q && !i_pend_q
    |=> !d_req || !i_req || (d_rdy && !i_rdy));
  // R7
  wr_drops_micro_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !d_uhit && !i_uhit);
endmodule

// File: tb/dual_port_tlb_test.sv
module dual_port_tlb_test;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [31:0] pa;
    logic        flt;
    logic [7:0]  lat;
    logic [7:0]  rq;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic i_req = 1'b0, d_req = 1'b0;
  logic [31:0] i_va = '0, d_va = '0;
  logic i_rdy, d_rdy, i_fault, d_fault;
  logic [31:0] i_pa, d_pa;
  logic wr_en = 1'b0, wr_valid = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [21:0] wr_vpn = '0, wr_ppn = '0;
  logic [1:0] wr_size = '0;

  exp_t iq[$], dq[$];
  int n_cmp = 0, n_bad = 0;
  int icnt = 0, dcnt = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  dual_port_tlb uut (
    .clk(clk), .rst(rst), .flush(flush),
    .i_req(i_req), .i_va(i_va), .i_rdy(i_rdy), .i_pa(i_pa), .i_fault(i_fault),
    .d_req(d_req), .d_va(d_va), .d_rdy(d_rdy), .d_pa(d_pa), .d_fault(d_fault),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_size(wr_size)
  );

  task automatic compare(input string port, input exp_t e, input logic [31:0] pa,
                         input logic flt, input int lat);
    n_cmp++;
    if (pa !== e.pa || flt !== e.flt || lat != int'(e.lat)) begin
      n_bad++;
      $display("FAIL R%0d %s: actual pa=%h fault=%b lat=%0d expected pa=%h fault=%b lat=%0d",
               e.rq, port, pa, flt, lat, e.pa, e.flt, e.lat);
    end
  endtask

  // monitor: pops one expected item per completed request
  always @(negedge clk) begin
    if (!rst && i_req) begin
      if (i_rdy) begin
        if (iq.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2 ifetch: actual unexpected completion expected none");
        end else compare("ifetch", iq.pop_front(), i_pa, i_fault, icnt);
        icnt = 0;
      end else icnt++;
    end
    if (!rst && d_req) begin
      if (d_rdy) begin
        if (dq.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2 data: actual unexpected completion expected none");
        end else compare("data", dq.pop_front(), d_pa, d_fault, dcnt);
        dcnt = 0;
      end else dcnt++;
    end
  end

  task automatic go(input bit dside, input logic [31:0] va, input logic [31:0] pa,
                    input bit flt, input int lat, input int rq);
    exp_t e;
    e.pa = pa; e.flt = flt; e.lat = lat[7:0]; e.rq = rq[7:0];
    if (dside) dq.push_back(e); else iq.push_back(e);
    @(posedge clk); #1;
    if (dside) begin d_req = 1'b1; d_va = va; end
    else begin i_req = 1'b1; i_va = va; end
    do @(negedge clk); while (!(dside ? d_rdy : i_rdy));
    @(posedge clk); #1;
    if (dside) d_req = 1'b0; else i_req = 1'b0;
  endtask

  task automatic wr(input int idx, input bit v, input logic [31:0] va,
                    input logic [31:0] pa, input logic [1:0] sz);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = idx[4:0]; wr_valid = v;
    wr_vpn = va[31:10]; wr_ppn = pa[31:10]; wr_size = sz;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: actual hung expected all requests complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 idle outputs after reset
    n_cmp++;
    if (i_rdy !== 1'b0 || d_rdy !== 1'b0 || i_fault !== 1'b0 || d_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 idle: actual rdy=%b%b fault=%b%b expected 00 00",
               i_rdy, d_rdy, i_fault, d_fault);
    end
    go(1, 32'h0030_0010, 32'h0, 1, 1, 11);                   // R11 empty after reset

    wr(3, 1, 32'h0000_1400, 32'h8000_0C00, 2'b00);          // 1 KB
    wr(5, 1, 32'h0002_0000, 32'h9000_3000, 2'b01);          // 4 KB
    wr(7, 1, 32'h0030_0000, 32'hA005_0000, 2'b10);          // 64 KB
    wr(9, 1, 32'h0700_0000, 32'hB010_0000, 2'b11);          // 1 MB

    go(1, 32'h0000_17FC, 32'h8000_0FFC, 0, 1, 2);           // R2 R4 1 KB
    go(1, 32'h0000_17FC, 32'h8000_0FFC, 0, 0, 1);           // R1 refilled
    go(0, 32'h0002_0ABC, 32'h9000_3ABC, 0, 1, 4);           // R4 4 KB
    go(0, 32'h0030_F123, 32'hA005_F123, 0, 1, 4);           // R4 64 KB
    go(0, 32'h070A_BCDE, 32'hB01A_BCDE, 0, 1, 4);           // R4 1 MB
    go(0, 32'h0002_0ABC, 32'h9000_3ABC, 0, 0, 1);           // R1

    go(1, 32'h0000_1800, 32'h0, 1, 1, 3);                   // R3 miss
    go(1, 32'h0000_1800, 32'h0, 1, 1, 3);                   // R3 not refilled

    go(1, 32'h0030_F123, 32'hA005_F123, 0, 1, 2);
    go(1, 32'h0030_F123, 32'hA005_F123, 0, 0, 1);
    wr(1, 1, 32'h0700_0000, 32'hC000_0000, 2'b11);          // overlaps index 9
    go(1, 32'h0030_F123, 32'hA005_F123, 0, 1, 7);           // R7 micro emptied
    go(1, 32'h070A_BCDE, 32'hC00A_BCDE, 0, 1, 9);           // R9 lowest index

    for (int k = 0; k < 5; k++)
      wr(10 + k, 1, 32'h0100_0000 + k * 32'h1000, 32'h2000_0000 + k * 32'h1000, 2'b01);
    for (int k = 0; k < 5; k++)                             // R5 instruction fills
      go(0, 32'h0100_0044 + k * 32'h1000, 32'h2000_0044 + k * 32'h1000, 0, 1, 5);
    go(0, 32'h0100_4044, 32'h2000_4044, 0, 0, 5);           // R5 newest kept
    go(0, 32'h0100_0044, 32'h2000_0044, 0, 1, 5);           // R5 oldest evicted
    for (int k = 0; k < 5; k++)
      go(1, 32'h0100_0044 + k * 32'h1000, 32'h2000_0044 + k * 32'h1000, 0, 1, 5);
    go(1, 32'h0100_0044, 32'h2000_0044, 0, 0, 5);           // R5 data side deeper

    wr(10, 1, 32'h0100_0000, 32'h2000_0000, 2'b01);
    fork                                                    // R6 simultaneous misses
      go(1, 32'h0100_3010, 32'h2000_3010, 0, 1, 6);
      go(0, 32'h0100_2020, 32'h2000_2020, 0, 2, 6);
    join

    wr(3, 0, 32'h0000_1400, 32'h8000_0C00, 2'b00);
    go(1, 32'h0000_17FC, 32'h0, 1, 1, 10);                  // R10 removed

    go(0, 32'h0002_0ABC, 32'h9000_3ABC, 0, 1, 8);
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    go(0, 32'h0002_0ABC, 32'h0, 1, 1, 8);                   // R8 all cleared

    repeat (3) @(posedge clk);
    if (iq.size() != 0 || dq.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 queues: actual %0d/%0d pending expected 0/0", iq.size(), dq.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule